// File: doc/BRIEF.md
# Comparator Control and Edge-Interrupt Register

This block is the digital side of an analog voltage comparator. It holds one 16-bit control and status word on a simple single-cycle bus. The word carries an enable, an output-polarity select and a two-bit output routing field, plus the settings for input select, response time and hysteresis. Those analog settings are only stored and driven out to the analog macro.

The raw comparator decision arrives asynchronously and passes through a two-flop synchronizer. The polarity bit is then applied and the result is gated by the enable. Rising and falling transitions of this conditioned signal set two sticky flags, and software clears a flag by writing 1 to it. Depending on the routing field, the conditioned level drives an output pin, or the flags drive an interrupt request.

A write happens in any cycle where `bus_wr` is high and `bus_addr` equals the parameter `REG_ADDR`. Read data is combinational and is zero when the address does not match.

Top module: `cmp_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x0000, and `cmp_irq`, `cmp_pin_out`, `neg_sel`, `resp_sel` and `hyst_en` are all low.
- R2: A write to `REG_ADDR` loads bits 10..2 from `bus_wdata`, and a read at `REG_ADDR` returns them at the same positions. A write to any other address changes nothing, and a read at any other address returns 0.
- R3: Bits 15..11 always read as zero, whatever was written.
- R4: The raw input is sampled through two flops. A flag set by a raw transition becomes visible after the third rising clock edge that follows the change, and `cmp_pin_out` follows after the second.
- R5: Bit 5 selects polarity. With 0 the conditioned signal equals the synchronized raw input. With 1 it is the inverse, so a falling raw input produces a rising conditioned edge.
- R6: `neg_sel` is bits 9..8 (00 half supply, 01 ADC channel 3, 10 DAC channel 0, 11 reserved), `resp_sel` is bits 4..3, and `hyst_en` is bit 2.
- R7: While bit 10 (enable) is 0, the conditioned signal is 0, no flag is set, and `cmp_pin_out` and `cmp_irq` stay low.
- R8: Bit 1 is set by a rising edge of the conditioned signal and bit 0 by a falling edge. Both are evaluated while enabled, and a 0-to-1 step caused by turning on the enable counts as a rising edge.
- R9: Writing 1 to bit 1 or bit 0 clears that flag, and writing 0 leaves it as it is. If a set and a clear of one flag fall in the same cycle, the flag ends up set.
- R10: `cmp_pin_out` equals the conditioned signal when bits 7..6 are 10, and is 0 for every other code.
- R11: `cmp_irq` is high exactly when bits 7..6 are 11, the enable is set, and at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when the address does not match |
| cmp_raw | input | 1 | Asynchronous comparator decision, high when the positive input is above the negative input |
| cmp_irq | output | 1 | Interrupt request |
| cmp_pin_out | output | 1 | Conditioned level for the external pin |
| neg_sel | output | 2 | Negative-input select to the analog macro |
| resp_sel | output | 2 | Response-time select to the analog macro |
| hyst_en | output | 1 | Hysteresis enable to the analog macro |

## Verification
A wrong stored field shows up at once on the read port and on the exported analog settings, because every read and every clock is compared against a behavioural model. A fault in the synchronizer or in the edge history moves the cycle at which a flag appears. The bench sees this within three clocks of a raw transition, in the read data and, when interrupt routing is selected, on `cmp_irq`. A flag that leaks through while disabled, or a clear that wins over a simultaneous set, leaves a flag bit that differs from the model on the very next read.

// File: rtl/cmp_ctrl_pkg.sv
// Package: shared field layout and types for the comparator control register.
// Assumes a 16-bit register word; bit positions are fixed because software
// decodes them.
package cmp_ctrl_pkg;

    localparam int REG_W      = 16;
    localparam int BIT_EN     = 10;
    localparam int BIT_NSEL   = 8;   // two bits, 9..8
    localparam int BIT_OCFG   = 6;   // two bits, 7..6
    localparam int BIT_POL    = 5;
    localparam int BIT_RESP   = 3;   // two bits, 4..3
    localparam int BIT_HYST   = 2;
    localparam int BIT_RISE   = 1;
    localparam int BIT_FALL   = 0;
    localparam int USED_W     = BIT_EN + 1;

    // Output routing codes
    typedef enum logic [1:0] {
        OCFG_RSV0 = 2'b00,
        OCFG_RSV1 = 2'b01,
        OCFG_PIN  = 2'b10,
        OCFG_IRQ  = 2'b11
    } ocfg_e;

    // Writable control fields (flags kept separately)
    typedef struct packed {
        logic       en;
        logic [1:0] nsel;
        ocfg_e      ocfg;
        logic       pol;
        logic [1:0] resp;
        logic       hyst;
    } cmp_ctl_t;

endpackage

// File: rtl/cmp_sync.sv
// Module: cmp_sync
// Multi-flop synchronizer for a single asynchronous bit.
// Assumes STAGES >= 2; the output lags the input by STAGES clock edges.
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] stg;

    // First stage captures the asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= 1'b0;
        else        stg[0] <= d_async;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each further stage resamples the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) stg[gi] <= 1'b0;
                else        stg[gi] <= stg[gi-1];
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/cmp_edge_det.sv
// Module: cmp_edge_det
// Applies polarity and enable to the synchronized comparator bit and
// produces one-cycle rise and fall events of the conditioned level.
// Assumes the input is already synchronous to clk. Events are suppressed
// while disabled; the history register keeps tracking the level.
module cmp_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic en,
    input  logic pol,
    output logic cond,
    output logic rise_evt,
    output logic fall_evt
);

    logic prev_q;

    // Conditioned level: inverted when pol is set, forced low when disabled
    always_comb begin
        cond = en & (sync_in ^ pol);
    end

    // Remember last conditioned level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cond;
    end

    // Edge events, gated by the enable
    always_comb begin
        rise_evt = en &  cond & ~prev_q;
        fall_evt = en & ~cond &  prev_q;
    end

endmodule

// File: rtl/cmp_reg_file.sv
// Module: cmp_reg_file
// Storage for the control fields and the two sticky edge flags.
// Assumes wr_hit is already address-qualified. Flags are write-1-to-clear;
// a hardware set in the same cycle as a clear takes priority.
module cmp_reg_file
    import cmp_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [USED_W-1:0] wdata,
    input  logic              rise_evt,
    input  logic              fall_evt,
    output cmp_ctl_t          ctl,
    output logic              rise_flag,
    output logic              fall_flag
);

    logic clr_rise;
    logic clr_fall;

    // Decode write-1-to-clear requests
    always_comb begin
        clr_rise = wr_hit & wdata[BIT_RISE];
        clr_fall = wr_hit & wdata[BIT_FALL];
    end

    // Control field storage, loaded on an addressed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '{en: 1'b0, nsel: 2'b00, ocfg: OCFG_RSV0, pol: 1'b0,
                     resp: 2'b00, hyst: 1'b0};
        end else if (wr_hit) begin
            ctl.en   <= wdata[BIT_EN];
            ctl.nsel <= wdata[BIT_NSEL +: 2];
            ctl.ocfg <= ocfg_e'(wdata[BIT_OCFG +: 2]);
            ctl.pol  <= wdata[BIT_POL];
            ctl.resp <= wdata[BIT_RESP +: 2];
            ctl.hyst <= wdata[BIT_HYST];
        end
    end

    // Sticky rise flag: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        rise_flag <= 1'b0;
        else if (rise_evt) rise_flag <= 1'b1;
        else if (clr_rise) rise_flag <= 1'b0;
    end

    // Sticky fall flag: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        fall_flag <= 1'b0;
        else if (fall_evt) fall_flag <= 1'b1;
        else if (clr_fall) fall_flag <= 1'b0;
    end

endmodule

// File: rtl/cmp_ctrl_reg.sv
// Module: cmp_ctrl_reg (top)
// Bus-mapped control/status register around an analog comparator:
// synchronizes the raw decision, conditions it, records edges and routes
// the result to a pin or an interrupt. Assumes single-cycle 16-bit access
// at REG_ADDR with combinational read data.
module cmp_ctrl_reg
    import cmp_ctrl_pkg::*;
#(
    parameter int               ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR   = 8'h44,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              cmp_raw,
    output logic              cmp_irq,
    output logic              cmp_pin_out,
    output logic [1:0]        neg_sel,
    output logic [1:0]        resp_sel,
    output logic              hyst_en
);

    logic        addr_hit;
    logic        wr_hit;
    logic        raw_sync;
    logic        cond;
    logic        rise_evt;
    logic        fall_evt;
    logic        rise_flag;
    logic        fall_flag;
    cmp_ctl_t    ctl;
    logic [REG_W-1:0] reg_val;
    logic        unused_wdata_hi;

    // Reserved write bits carry no meaning
    assign unused_wdata_hi = ^bus_wdata[REG_W-1:USED_W];

    // Address decode
    always_comb begin
        addr_hit = (bus_addr == REG_ADDR);
        wr_hit   = addr_hit & bus_wr;
    end

    cmp_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_raw),
        .q_sync  (raw_sync)
    );

    cmp_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (raw_sync),
        .en       (ctl.en),
        .pol      (ctl.pol),
        .cond     (cond),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    cmp_reg_file u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .wdata     (bus_wdata[USED_W-1:0]),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .ctl       (ctl),
        .rise_flag (rise_flag),
        .fall_flag (fall_flag)
    );

    // Assemble the readable word; reserved bits are zero
    always_comb begin
        reg_val                   = '0;
        reg_val[BIT_EN]           = ctl.en;
        reg_val[BIT_NSEL +: 2]    = ctl.nsel;
        reg_val[BIT_OCFG +: 2]    = ctl.ocfg;
        reg_val[BIT_POL]          = ctl.pol;
        reg_val[BIT_RESP +: 2]    = ctl.resp;
        reg_val[BIT_HYST]         = ctl.hyst;
        reg_val[BIT_RISE]         = rise_flag;
        reg_val[BIT_FALL]         = fall_flag;
    end

    // Read mux: only the decoded address returns data
    always_comb begin
        bus_rdata = addr_hit ? reg_val : '0;
    end

    // Output routing and analog settings export
    always_comb begin
        cmp_pin_out = (ctl.ocfg == OCFG_PIN) & cond;
        cmp_irq     = (ctl.ocfg == OCFG_IRQ) & ctl.en & (rise_flag | fall_flag);
        neg_sel     = ctl.nsel;
        resp_sel    = ctl.resp;
        hyst_en     = ctl.hyst;
    end

endmodule

// File: rtl/cmp_ctrl_chk.sv
// Module: cmp_ctrl_chk
// Property checker attached to cmp_ctrl_reg. Observes the bus, the stored
// enable/routing fields, the flags and the routed outputs.
module cmp_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_hit,
    input logic [1:0] wclr,
    input logic       en,
    input logic [1:0] ocfg,
    input logic       rise_flag,
    input logic       fall_flag,
    input logic       irq,
    input logic       pin
);

    AST_IRQ_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ocfg == 2'b11 && en && (rise_flag || fall_flag))); // R11

    AST_PIN_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        pin |-> (ocfg == 2'b10 && en)); // R10

    AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rise_flag) |-> $past(en)); // R7

    AST_FALL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fall_flag) |-> $past(en)); // R7

    AST_RISE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rise_flag) |-> $past(wr_hit && wclr[1])); // R9

    AST_FALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fall_flag) |-> $past(wr_hit && wclr[0])); // R9

endmodule

bind cmp_ctrl_reg cmp_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .wclr      (bus_wdata[1:0]),
    .en        (ctl.en),
    .ocfg      (ctl.ocfg),
    .rise_flag (rise_flag),
    .fall_flag (fall_flag),
    .irq       (cmp_irq),
    .pin       (cmp_pin_out)
);

// File: tb/test_cmp_ctrl_reg.sv
module test_cmp_ctrl_reg;

    localparam int       AW  = 8;
    localparam logic [7:0] REG = 8'h44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = REG;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cmp_raw = 1'b0;
    logic        cmp_irq, cmp_pin_out, hyst_en;
    logic [1:0]  neg_sel, resp_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cmp_ctrl_reg #(.ADDR_W(AW), .REG_ADDR(REG), .SYNC_STAGES(2)) i_cmp_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_raw(cmp_raw),
        .cmp_irq(cmp_irq), .cmp_pin_out(cmp_pin_out), .neg_sel(neg_sel),
        .resp_sel(resp_sel), .hyst_en(hyst_en)
    );

    // Behavioural reference model
    bit       m_en, m_pol, m_hyst, m_rf, m_ff, m_prev, m_live;
    bit [1:0] m_nsel, m_oc, m_resp;
    bit       dly[$];

    function automatic bit m_cond();
        return m_en ? (dly[0] ^ m_pol) : 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_pol = 0; m_hyst = 0; m_rf = 0; m_ff = 0; m_prev = 0;
            m_nsel = 0; m_oc = 0; m_resp = 0;
            dly = '{1'b0, 1'b0};
            m_live = 1;
        end else begin
            bit c, up, dn, hit;
            c   = m_cond();
            up  = m_en && c && !m_prev;
            dn  = m_en && !c && m_prev;
            hit = bus_wr && (bus_addr == REG);
            m_prev = c;
            if (up) m_rf = 1; else if (hit && bus_wdata[1]) m_rf = 0;
            if (dn) m_ff = 1; else if (hit && bus_wdata[0]) m_ff = 0;
            if (hit) begin
                m_en   = bus_wdata[10];
                m_nsel = bus_wdata[9:8];
                m_oc   = bus_wdata[7:6];
                m_pol  = bus_wdata[5];
                m_resp = bus_wdata[4:3];
                m_hyst = bus_wdata[2];
            end
            dly.push_back(cmp_raw);
            void'(dly.pop_front());
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (rst_n && m_live) begin
            logic [15:0] er;
            er = (bus_addr == REG) ?
                 {5'b0, m_en, m_nsel, m_oc, m_pol, m_resp, m_hyst, m_rf, m_ff} : 16'h0;
            chk("R2 model rdata", bus_rdata, er);
            chk("R10 model pin", {15'b0, cmp_pin_out}, {15'b0, (m_oc == 2'b10) && m_cond()});
            chk("R11 model irq", {15'b0, cmp_irq}, {15'b0, (m_oc == 2'b11) && m_en && (m_rf || m_ff)});
            chk("R6 model exports", {11'b0, neg_sel, resp_sel, hyst_en},
                {11'b0, m_nsel, m_resp, m_hyst});
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_addr = REG;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        step(3);
        @(negedge clk);
        chk("R1 reset rdata", bus_rdata, 16'h0000);
        chk("R1 reset outs", {11'b0, cmp_irq, cmp_pin_out, neg_sel, resp_sel, hyst_en}, 16'h0);
        step();
        rst_n = 1'b1;
        step(2);

        // R2/R3/R6: all ones written
        wr(REG, 16'hFFFF);
        @(negedge clk);
        chk("R3 reserved zero", {11'b0, bus_rdata[15:11]}, 16'h0);
        chk("R2 fields", {7'b0, bus_rdata[10:2]}, 16'h01FF);
        chk("R6 exports", {11'b0, neg_sel, resp_sel, hyst_en}, 16'h001F);
        step(4);
        wr(REG, 16'h0000);
        step(3);
        wr(REG, 16'h0003);
        @(negedge clk);
        chk("R9 cleared all", bus_rdata, 16'h0000);

        // R2: foreign address write ignored, read returns 0
        wr(8'h40, 16'h07FC);
        @(negedge clk);
        chk("R2 foreign write ignored", bus_rdata, 16'h0000);
        bus_addr = 8'h40;
        wr(REG, 16'h0118);
        bus_addr = 8'h40;
        @(negedge clk);
        chk("R2 foreign read zero", bus_rdata, 16'h0000);
        bus_addr = REG;
        @(negedge clk);
        chk("R6 nsel/resp", {12'b0, neg_sel, resp_sel}, 16'h0007);

        // R4/R8/R10: enabled, pin routing, positive polarity
        wr(REG, 16'h0480);
        step(2);
        wr(REG, 16'h0483);
        cmp_raw = 1'b1;
        step(2);
        @(negedge clk);
        chk("R4 rise not yet", {15'b0, bus_rdata[1]}, 16'h0);
        chk("R10 pin follows", {15'b0, cmp_pin_out}, 16'h1);
        step();
        @(negedge clk);
        chk("R4 R8 rise flag", {14'b0, bus_rdata[1:0]}, 16'h2);
        chk("R11 no irq on pin route", {15'b0, cmp_irq}, 16'h0);

        // R9: write 0 keeps, write 1 clears
        wr(REG, 16'h0480);
        @(negedge clk);
        chk("R9 write0 keeps", {15'b0, bus_rdata[1]}, 16'h1);
        wr(REG, 16'h0482);
        @(negedge clk);
        chk("R9 write1 clears", {15'b0, bus_rdata[1]}, 16'h0);

        // R8: falling edge
        cmp_raw = 1'b0;
        step(3);
        @(negedge clk);
        chk("R8 fall flag", {14'b0, bus_rdata[1:0]}, 16'h1);

        // R11: irq routing with enable
        wr(REG, 16'h04C0);
        @(negedge clk);
        chk("R11 irq on", {15'b0, cmp_irq}, 16'h1);
        wr(REG, 16'h00C0);
        @(negedge clk);
        chk("R11 irq off when disabled", {15'b0, cmp_irq}, 16'h0);

        // R7: disabled, toggling input sets nothing
        wr(REG, 16'h0083);
        cmp_raw = 1'b1; step(4);
        cmp_raw = 1'b0; step(4);
        @(negedge clk);
        chk("R7 no flags disabled", {14'b0, bus_rdata[1:0]}, 16'h0);
        chk("R7 pin low disabled", {15'b0, cmp_pin_out}, 16'h0);

        // R5: inverted polarity, irq routing
        wr(REG, 16'h04E3);
        step(3);
        wr(REG, 16'h04E3);
        step(2);
        cmp_raw = 1'b1;
        step(4);
        @(negedge clk);
        chk("R5 inverted gives fall", {14'b0, bus_rdata[1:0]}, 16'h1);
        chk("R5 R11 irq", {15'b0, cmp_irq}, 16'h1);

        // R9: set wins over simultaneous clear
        wr(REG, 16'h0483);
        cmp_raw = 1'b0;
        step(4);
        wr(REG, 16'h0483);
        step(2);
        cmp_raw = 1'b1;
        step(2);
        wr(REG, 16'h0482);
        @(negedge clk);
        chk("R9 set wins", {15'b0, bus_rdata[1]}, 16'h1);

        step(4);
        summary();
    end

endmodule